// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block receives stereo PCM audio carried on three wires: a bit clock, a word clock that marks which channel is being sent, and a serial data line. It turns that stream into a pair of 24-bit signed samples, one for the left channel and one for the right channel. A one-cycle strobe marks each complete frame. The three serial lines are asynchronous to the system clock. They are brought into the system domain through synchronisers, and bit-clock rising edges are detected there. The system clock must therefore be fast enough to oversample the bit clock by a comfortable margin.

A 3-bit format select picks the framing:
- 16-bit LSB-justified.
- 20-bit LSB-justified.
- 24-bit LSB-justified.
- 24-bit MSB-justified.
- I2S-compatible.

Each format has its own minimum bit-clock ratio. Words shorter than 24 bits are left-aligned into the output, so a full-scale code reaches the same output level in every format. The select is expected to stay fixed while the block is out of reset. A format change is made with a reset.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `valid_o` is 0 and both sample outputs are 0.
- R2: Serial data is two's complement, sent MSB first, and sampled on bit-clock rising edges. With `fmt_i` = 3'b000 (16-bit LSB-justified), the LSB is in the last bit period of each half-frame. The sample is output as `{word[15:0], 8'h00}`. The block works at both 32 and 64 bit clocks per frame.
- R3: With `fmt_i` = 3'b001 (20-bit LSB-justified), the LSB is in the last bit period of each half-frame. The sample is output as `{word[19:0], 4'h0}`. The block works at both 40 and 64 bit clocks per frame.
- R4: With `fmt_i` = 3'b100 (24-bit LSB-justified), the 24-bit word ends in the last bit period of each half-frame. The block works at both 48 and 64 bit clocks per frame.
- R5: With `fmt_i` = 3'b010 (24-bit MSB-justified), the MSB is in the first bit period after a word-clock change. The 24 bits are output unchanged. A 16-bit or 20-bit word padded with zero LSBs is recovered exactly. The block works at both 48 and 64 bit clocks per frame.
- R6: With `fmt_i` = 3'b011 (I2S-compatible), the MSB arrives one bit period after a word-clock change. At 48 bit clocks per frame, the LSB therefore falls in the first bit period of the following half-frame. The block works at both 48 and 64 bit clocks per frame.
- R7: Channel polarity depends on the format. In I2S mode a low word clock marks left data. In all other formats a high word clock marks left data. A frame is a left half followed by a right half.
- R8: `valid_o` pulses for exactly one cycle per frame, after the right sample of that frame is captured. It pulses only if that frame's left sample was captured first. It never stays high for two consecutive cycles.
- R9: Bits outside the data word have no effect on the outputs. These are the bits before the word in LSB-justified formats, and the bits after it in the other formats.
- R10: `left_o` and `right_o` change only in the cycle in which `valid_o` is high. They hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Word clock marking the channel (asynchronous) |
| sdata_i | input | 1 | Serial audio data (asynchronous) |
| fmt_i | input | 3 | Framing format select |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe when a new frame is on the outputs |

## Verification
The assertions check the following on every cycle:
- The output state right after reset.
- That the strobe is a single-cycle pulse.
- That the sample outputs hold between strobes.
- That the zero padding for 16-bit and 20-bit words is present.

Which bits land in which output, channel polarity, and the one-bit I2S offset can only be shown by the bench's scenarios. The same holds for the LSB spilling into the next half-frame at 48 bit clocks, and for don't-care bits being ignored. The bench covers these by driving every format at 64fs and at its minimum ratio, with full-scale and random words, and compares each strobed frame against what was sent.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [2:0] {
    FMT_LSB16 = 3'd0,
    FMT_LSB20 = 3'd1,
    FMT_MSB24 = 3'd2,
    FMT_I2S   = 3'd3,
    FMT_LSB24 = 3'd4
  } fmt_e;

  // Word width selector: 0 -> 16 bits, 1 -> 20 bits, 2 -> full width
  typedef struct packed {
    logic       lsb_just;
    logic       i2s;
    logic [1:0] wsel;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_fmt(input logic [2:0] code);
    frame_cfg_t c;
    c = '{lsb_just: 1'b1, i2s: 1'b0, wsel: 2'd2};
    case (code)
      FMT_LSB16: c.wsel = 2'd0;
      FMT_LSB20: c.wsel = 2'd1;
      FMT_MSB24: c.lsb_just = 1'b0;
      FMT_I2S:   begin c.lsb_just = 1'b0; c.i2s = 1'b1; end
      default:   c.wsel = 2'd2;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/asr_frame_track.sv
module asr_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic bclk_s,
  input  logic wclk_s,
  input  logic i2s,
  output logic bit_stb,
  output logic frame_edge,
  output logic cur_right
);
  logic       bclk_q;
  logic       w_d1;
  logic       w_eff_d;
  logic [1:0] prime;
  logic       w_eff;
  logic       rise;

  always_comb begin
    rise       = bclk_s & ~bclk_q;
    // I2S frames run one bit behind the word clock: use the delayed level
    w_eff      = i2s ? w_d1 : wclk_s;
    bit_stb    = rise;
    frame_edge = rise && (prime == 2'd2) && (w_eff != w_eff_d);
    cur_right  = i2s ? w_eff : ~w_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      w_d1    <= 1'b0;
      w_eff_d <= 1'b0;
      prime   <= 2'd0;
    end else begin
      bclk_q <= bclk_s;
      if (rise) begin
        w_d1    <= wclk_s;
        w_eff_d <= w_eff;
        if (prime != 2'd2) prime <= prime + 2'd1;
      end
    end
  end
endmodule

// File: rtl/asr_word_capture.sv
module asr_word_capture #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic                frame_edge,
  input  logic                cur_right,
  input  logic                lsb_just,
  input  logic [1:0]          wsel,
  output logic                cap_stb,
  output logic                cap_right,
  output logic [SAMPLE_W-1:0] cap_word
);
  localparam int PAD16 = SAMPLE_W - 16;
  localparam int PAD20 = SAMPLE_W - 20;
  localparam logic [CNT_W-1:0] IDX_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] sh, sh_next, src, aligned;
  logic [CNT_W-1:0]    idx_q, idx;
  logic                armed, armed_now, lsb_hit, msb_hit;

  always_comb begin
    sh_next   = {sh[SAMPLE_W-2:0], bit_val};
    idx       = frame_edge ? '0 : ((idx_q == IDX_MAX) ? IDX_MAX : idx_q + 1'b1);
    armed_now = armed | frame_edge;
    // LSB-justified: the word just ended at the previous bit, already in sh
    lsb_hit   = lsb_just && frame_edge && armed;
    msb_hit   = !lsb_just && armed_now && (idx == IDX_LAST);
    src       = lsb_just ? sh : sh_next;
    case (wsel)
      2'd0:    aligned = src << PAD16;
      2'd1:    aligned = src << PAD20;
      default: aligned = src;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      idx_q     <= '0;
      armed     <= 1'b0;
      cap_stb   <= 1'b0;
      cap_right <= 1'b0;
      cap_word  <= '0;
    end else begin
      cap_stb <= bit_stb && (lsb_hit || msb_hit);
      if (bit_stb) begin
        sh    <= sh_next;
        idx_q <= idx;
        armed <= armed_now;
        if (lsb_hit || msb_hit) begin
          cap_right <= lsb_hit ? ~cur_right : cur_right;
          cap_word  <= aligned;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_RATIO   = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  import asr_pkg::*;

  localparam int CNT_W = $clog2(MAX_RATIO / 2 + 1);

  frame_cfg_t          cfg;
  logic [2:0]          sync_q;
  logic                bit_stb, frame_edge, cur_right;
  logic                cap_stb, cap_right;
  logic [SAMPLE_W-1:0] cap_word, left_hold;
  logic                have_left;

  assign cfg = decode_fmt(fmt_i);

  asr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({sdata_i, wclk_i, bclk_i}),
    .dout(sync_q)
  );

  asr_frame_track u_track (
    .clk(clk), .rst(rst),
    .bclk_s(sync_q[0]), .wclk_s(sync_q[1]), .i2s(cfg.i2s),
    .bit_stb(bit_stb), .frame_edge(frame_edge), .cur_right(cur_right)
  );

  asr_word_capture #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst),
    .bit_stb(bit_stb), .bit_val(sync_q[2]),
    .frame_edge(frame_edge), .cur_right(cur_right),
    .lsb_just(cfg.lsb_just), .wsel(cfg.wsel),
    .cap_stb(cap_stb), .cap_right(cap_right), .cap_word(cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_stb) begin
        if (!cap_right) begin
          left_hold <= cap_word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= cap_word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/asr_checker.sv
module asr_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          fmt_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o
);
  localparam int PAD16 = SAMPLE_W - 16;
  localparam int PAD20 = SAMPLE_W - 20;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!valid_o && left_o == '0 && right_o == '0)); // R1

  AST_LSB16_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fmt_i == 3'd0) |-> (left_o[PAD16-1:0] == '0 && right_o[PAD16-1:0] == '0)); // R2

  AST_LSB20_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fmt_i == 3'd1) |-> (left_o[PAD20-1:0] == '0 && right_o[PAD20-1:0] == '0)); // R3

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R8

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R10
endmodule

bind audio_serial_rx asr_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .fmt_i(fmt_i),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;
  localparam int NF   = 6;
  localparam int SLOT = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;

  logic        sw [SLOT];
  logic        sd [SLOT];
  logic [23:0] el [NF];
  logic [23:0] er [NF];
  logic [23:0] gl [NF+2];
  logic [23:0] gr [NF+2];
  int          got_n = 0;
  logic        mon_clr = 1'b0;

  always #5 clk = ~clk;

  audio_serial_rx u0 (
    .clk(clk), .rst(rst), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (mon_clr) got_n <= 0;
    else if (!rst && valid_o) begin
      if (got_n < NF + 2) begin
        gl[got_n] <= left_o;
        gr[got_n] <= right_o;
      end
      got_n <= got_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] f);
    return (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] align(input logic [2:0] f, input logic [23:0] v);
    case (f)
      3'd0:    return {v[15:0], 8'h00};
      3'd1:    return {v[19:0], 4'h0};
      default: return v;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0:    return "R2 R7 R9";
      3'd1:    return "R3 R7 R9";
      3'd2:    return "R5 R7 R9";
      3'd3:    return "R6 R7 R9";
      default: return "R4 R7 R9";
    endcase
  endfunction

  task automatic drive_slot(input logic w, input logic d);
    @(negedge clk);
    bclk = 1'b0; wclk = w; sdata = d;
    repeat (7) @(negedge clk);
    bclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic overlay(input logic [2:0] f, input int start, input int half, input logic [23:0] v);
    int n = wbits(f);
    if (f == 3'd2) begin
      for (int k = 0; k < 24; k++) sd[start + k] = v[23 - k];
    end else if (f == 3'd3) begin
      for (int k = 0; k < 24; k++) sd[start + 1 + k] = v[23 - k];
    end else begin
      for (int k = 0; k < n; k++) sd[start + half - n + k] = v[n - 1 - k];
    end
  endtask

  task automatic run_session(input logic [2:0] f, input int ratio);
    int half = ratio / 2;
    int n = wbits(f);
    int halves = 2 * NF + 2;
    logic lvl_left = (f == 3'd3) ? 1'b0 : 1'b1;
    logic [23:0] vl, vr;
    rst = 1'b1; fmt = f; bclk = 1'b0; wclk = ~lvl_left; sdata = 1'b0;
    mon_clr = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
    rst = 1'b0;
    for (int h = 0; h < halves; h++)
      for (int p = 0; p < half; p++) begin
        sw[h * half + p] = (h % 2 == 1) ? lvl_left : ~lvl_left;
        sd[h * half + p] = 1'($urandom);
      end
    for (int fr = 0; fr < NF; fr++) begin
      if (fr == 0) begin
        vl = 24'((1 << (n - 1)) - 1);
        vr = 24'(1 << (n - 1));
      end else if (fr == 1) begin
        vl = 24'h000000;
        vr = 24'hFFFFFF;
      end else begin
        vl = 24'($urandom);
        vr = 24'($urandom);
        if (f == 3'd2 && fr == 2) begin vl[3:0] = 4'h0; vr[3:0] = 4'h0; end
        if (f == 3'd2 && fr == 3) begin vl[7:0] = 8'h0; vr[7:0] = 8'h0; end
      end
      overlay(f, (2 * fr + 1) * half, half, vl);
      overlay(f, (2 * fr + 2) * half, half, vr);
      el[fr] = align(f, vl);
      er[fr] = align(f, vr);
    end
    for (int s = 0; s < halves * half; s++) drive_slot(sw[s], sd[s]);
    repeat (40) @(negedge clk);
    check(got_n == NF, "R8 strobe count", 24'(got_n), 24'(NF));
    for (int fr = 0; fr < NF && fr < got_n; fr++) begin
      check(gl[fr] == el[fr], {req_of(f), " left"},  gl[fr], el[fr]);
      check(gr[fr] == er[fr], {req_of(f), " right"}, gr[fr], er[fr]);
    end
    // R10: outputs hold the last frame after the stream stops
    repeat (50) @(negedge clk);
    check(left_o == el[NF-1] && !valid_o, "R10 hold", left_o, el[NF-1]);
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h1A2B);
    repeat (3) @(negedge clk);
    check(left_o == 24'h0 && right_o == 24'h0 && !valid_o, "R1 reset", left_o, 24'h0);
    rst = 1'b0;
    @(negedge clk);
    check(right_o == 24'h0 && !valid_o, "R1 after reset", right_o, 24'h0);
    run_session(3'd0, 64);
    run_session(3'd0, 32);
    run_session(3'd1, 64);
    run_session(3'd1, 40);
    run_session(3'd4, 64);
    run_session(3'd4, 48);
    run_session(3'd2, 64);
    run_session(3'd2, 48);
    run_session(3'd3, 64);
    run_session(3'd3, 48);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule